// File: doc/BRIEF.md
# Display Data Channel Slave with Variable-Length Address

This block is the bus-facing front end of a display data channel target. It watches an already synchronized two-wire serial clock and data pair and decodes start and stop conditions. It compares each address byte against a programmed 7-bit device address. A configuration field can shorten that comparison to the upper 6 or 5 bits, so one device answers at a group of neighbouring addresses. After a match it acknowledges the address and runs a data phase against an external 128-entry byte memory.

In a write transfer, the first data byte sets the memory word offset. Each later byte is stored at the offset, and the offset then advances, wrapping within the memory. A separate permission bit can block the stores while the bus still sees every byte acknowledged. In a read transfer, the block streams bytes from the current offset. It moves to the next byte while the master acknowledges and releases the bus after a not-acknowledge.

Stop conditions and repeated starts are reported as one-cycle pulses. A further pulse marks the stop that ends a transfer in which this slave was addressed for writing. A ready output tells the legacy one-way transfer logic that the bus is idle and that legacy mode is switched on.

Top module: `ddc_slave`

## Requirements
- R1: The address byte carries the 7-bit address MSB first, followed by a direction bit (1 = read). With `cfg_alen` = 00 or 11, all 7 bits must equal `cfg_addr`. On a match the slave holds SDA low for the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R2: With `cfg_alen` = 10, only address bits 6..2 are compared, so the two low bits are don't-care.
- R3: With `cfg_alen` = 01, only address bits 6..1 are compared, so bit 0 is don't-care.
- R4: While `cfg_en` is 0, the slave never pulls SDA, never writes memory and raises no event pulse.
- R5: In a write transfer, bits 6..0 of the first data byte set the offset. Each later byte is written at the offset with a single-cycle `mem_we`, and the offset then increments modulo 128.
- R6: While `cfg_wr_permit` is 0, data bytes are still acknowledged and the offset still advances, but `mem_we` stays low.
- R7: In a read transfer, bytes are sent MSB first starting at the current offset, and the offset increments after each byte. The slave continues while the master acknowledges, and releases SDA after a not-acknowledge.
- R8: Each stop condition gives one `ev_stop` pulse. A start seen while the bus is already busy gives one `ev_restart` pulse.
- R9: `ev_wstop` pulses together with `ev_stop` only when the ending transfer contained an acknowledged write-direction address for this slave. A read-only transfer gives no such pulse.
- R10: `ddc1_ready` is high exactly when `cfg_en` and `cfg_ddc1_en` are both 1 and no transfer is in progress since the last stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized serial clock |
| sda_in | input | 1 | Synchronized serial data (resolved bus level) |
| cfg_en | input | 1 | Slave enable |
| cfg_alen | input | 2 | Address compare length code |
| cfg_wr_permit | input | 1 | Allows master writes into memory |
| cfg_ddc1_en | input | 1 | Legacy one-way transfer enable |
| cfg_addr | input | 7 | Programmed device address |
| sda_pull | output | 1 | Drives SDA low when 1 |
| mem_addr | output | 7 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, combinational |
| ev_stop | output | 1 | Stop condition pulse |
| ev_restart | output | 1 | Repeated start pulse |
| ev_wstop | output | 1 | Stop after a write transfer pulse |
| ddc1_ready | output | 1 | Legacy transfer may run |

## Verification
The acknowledge pull-down and every read data bit change on the first clock edge after SCL is seen low. The bench therefore waits one full clock after lowering SCL before raising it, and samples SDA one clock into the high phase. A memory store appears one clock after the falling edge that closes the eighth data bit, so memory contents are compared only after the whole transfer. The event pulses follow the detected condition by one clock. They are counted on falling clock edges, and the counts are compared only after at least two further clocks of idle bus, so a check never lands on the edge where a pulse is still being produced.

// File: rtl/ddc_slave_pkg.sv
package ddc_slave_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK
   } ddc_state_e;

   localparam logic [1:0] ALEN_7 = 2'b00;
   localparam logic [1:0] ALEN_6 = 2'b01;
   localparam logic [1:0] ALEN_5 = 2'b10;

endpackage

// File: rtl/ddc_bus_cond.sv
module ddc_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/ddc_addr_match.sv
module ddc_addr_match
   import ddc_slave_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int MAX_DROP = 2
) (
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [1:0]        alen,
   output logic              hit
);
   localparam int DW = $clog2(MAX_DROP + 1);

   if (MAX_DROP < 2 || MAX_DROP >= ADDR_W) begin : g_bad_drop
      $error("ddc_addr_match: MAX_DROP must be at least 2 and below ADDR_W");
   end

   logic [DW-1:0]     drop;
   logic [ADDR_W-1:0] bit_ok;

   always_comb begin
      case (alen)
         ALEN_5:  drop = DW'(2);
         ALEN_6:  drop = DW'(1);
         default: drop = '0;
      endcase
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < MAX_DROP) begin : g_maskable
         assign bit_ok[i] = (own_addr[i] == rx_addr[i]) | (drop > DW'(i));
      end else begin : g_fixed
         assign bit_ok[i] = (own_addr[i] == rx_addr[i]);
      end
   end

   assign hit = &bit_ok;
endmodule

// File: rtl/ddc_offset_ctr.sv
module ddc_offset_ctr #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (inc)  value <= value + AW'(1);
   end
endmodule

// File: rtl/ddc_slave.sv
module ddc_slave
   import ddc_slave_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int MEM_AW = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_alen,
   input  logic              cfg_wr_permit,
   input  logic              cfg_ddc1_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   output logic              sda_pull,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ev_stop,
   output logic              ev_restart,
   output logic              ev_wstop,
   output logic              ddc1_ready
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   if (DATA_W != ADDR_W + 1) begin : g_bad_data_w
      $error("ddc_slave: DATA_W must be ADDR_W + 1");
   end
   if (MEM_AW > DATA_W - 1) begin : g_bad_mem_aw
      $error("ddc_slave: MEM_AW must fit in one data byte without its top bit");
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   logic hit;
   logic [MEM_AW-1:0] offset;
   logic off_load, off_inc, adv, byte_done;

   ddc_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] rx_q, tx_q, wdata_q;
   logic [MEM_AW-1:0] waddr_q;
   logic rw_q, first_q, wrote_q, busy_q, nack_q;
   logic pull_q, we_q, evs_q, evr_q, evw_q;

   ddc_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl       (scl_in),
      .sda       (sda_in),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ddc_addr_match #(.ADDR_W(ADDR_W), .MAX_DROP(2)) u_match (
      .own_addr (cfg_addr),
      .rx_addr  (rx_q[DATA_W-1:1]),
      .alen     (cfg_alen),
      .hit      (hit)
   );

   assign adv       = cfg_en & ~start_det & ~stop_det;
   assign byte_done = scl_fall & (cnt_q == FULL);
   assign off_load  = adv & (st_q == ST_WR) & byte_done & first_q;
   assign off_inc   = adv & byte_done & (((st_q == ST_WR) & ~first_q) | (st_q == ST_RD));

   ddc_offset_ctr #(.AW(MEM_AW)) u_off (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (off_load),
      .load_val (rx_q[MEM_AW-1:0]),
      .inc      (off_inc),
      .value    (offset)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         wdata_q <= '0;
         waddr_q <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         wrote_q <= 1'b0;
         busy_q  <= 1'b0;
         nack_q  <= 1'b0;
         pull_q  <= 1'b0;
         we_q    <= 1'b0;
         evs_q   <= 1'b0;
         evr_q   <= 1'b0;
         evw_q   <= 1'b0;
      end else begin
         we_q  <= 1'b0;
         evs_q <= 1'b0;
         evr_q <= 1'b0;
         evw_q <= 1'b0;
         if (!cfg_en) begin
            st_q    <= ST_IDLE;
            pull_q  <= 1'b0;
            busy_q  <= 1'b0;
            wrote_q <= 1'b0;
         end else if (start_det) begin
            evr_q  <= busy_q;
            busy_q <= 1'b1;
            st_q   <= ST_ADDR;
            cnt_q  <= '0;
            pull_q <= 1'b0;
         end else if (stop_det) begin
            evs_q   <= 1'b1;
            evw_q   <= wrote_q;
            wrote_q <= 1'b0;
            busy_q  <= 1'b0;
            st_q    <= ST_IDLE;
            pull_q  <= 1'b0;
         end else begin
            case (st_q)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[DATA_W-2:0], sda_in};
                     cnt_q <= cnt_q + CNT_W'(1);
                  end else if (byte_done) begin
                     if (st_q == ST_ADDR) begin
                        if (hit) begin
                           pull_q  <= 1'b1;
                           rw_q    <= rx_q[0];
                           first_q <= 1'b1;
                           st_q    <= ST_AACK;
                           if (!rx_q[0]) wrote_q <= 1'b1;
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else begin
                        pull_q <= 1'b1;
                        st_q   <= ST_WACK;
                        if (first_q) begin
                           first_q <= 1'b0;
                        end else if (cfg_wr_permit) begin
                           we_q    <= 1'b1;
                           wdata_q <= rx_q;
                           waddr_q <= offset;
                        end
                     end
                  end
               end
               ST_AACK, ST_RACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_in;
                  end else if (scl_fall) begin
                     if ((st_q == ST_AACK && !rw_q)) begin
                        pull_q <= 1'b0;
                        cnt_q  <= '0;
                        st_q   <= ST_WR;
                     end else if (st_q == ST_RACK && nack_q) begin
                        pull_q <= 1'b0;
                        st_q   <= ST_IDLE;
                     end else begin
                        tx_q   <= {mem_rdata[DATA_W-2:0], 1'b0};
                        pull_q <= ~mem_rdata[DATA_W-1];
                        cnt_q  <= CNT_W'(1);
                        st_q   <= ST_RD;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     pull_q <= 1'b0;
                     cnt_q  <= '0;
                     st_q   <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (byte_done) begin
                     pull_q <= 1'b0;
                     st_q   <= ST_RACK;
                  end else if (scl_fall) begin
                     pull_q <= ~tx_q[DATA_W-1];
                     tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                     cnt_q  <= cnt_q + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull   = pull_q;
   assign mem_we     = we_q;
   assign mem_wdata  = wdata_q;
   assign mem_addr   = we_q ? waddr_q : offset;
   assign ev_stop    = evs_q;
   assign ev_restart = evr_q;
   assign ev_wstop   = evw_q;
   assign ddc1_ready = cfg_en & cfg_ddc1_en & ~busy_q;
endmodule

// File: rtl/ddc_slave_chk.sv
module ddc_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic cfg_en,
   input logic cfg_wr_permit,
   input logic sda_pull,
   input logic mem_we,
   input logic ev_stop,
   input logic ev_restart,
   input logic ev_wstop,
   input logic ddc1_ready
);
   a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cfg_en) |-> (!sda_pull && !mem_we && !ev_stop && !ev_restart && !ev_wstop));

   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r6_we_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(cfg_wr_permit));

   a_r8_stop_restart_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_stop && ev_restart));

   a_r8_stop_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |-> $past(scl_in));

   a_r9_wstop_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wstop |-> ev_stop);

   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ddc1_ready |-> !sda_pull);
endmodule

bind ddc_slave ddc_slave_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_in        (scl_in),
   .cfg_en        (cfg_en),
   .cfg_wr_permit (cfg_wr_permit),
   .sda_pull      (sda_pull),
   .mem_we        (mem_we),
   .ev_stop       (ev_stop),
   .ev_restart    (ev_restart),
   .ev_wstop      (ev_wstop),
   .ddc1_ready    (ddc1_ready)
);

// File: tb/ddc_slave_test.sv
module ddc_slave_test;
   localparam logic [6:0] OWN = 7'h50;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl = 1'b1, m_sda = 1'b1;
   logic sda_bus;
   logic cfg_en = 1'b1, cfg_wr_permit = 1'b1, cfg_ddc1_en = 1'b0;
   logic [1:0] cfg_alen = 2'b00;
   logic [6:0] cfg_addr = OWN;
   logic sda_pull, mem_we, ev_stop, ev_restart, ev_wstop, ddc1_ready;
   logic [6:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic [7:0] ram [128];

   assign sda_bus   = m_sda & ~sda_pull;
   assign mem_rdata = ram[mem_addr];

   ddc_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
      .cfg_en(cfg_en), .cfg_alen(cfg_alen), .cfg_wr_permit(cfg_wr_permit),
      .cfg_ddc1_en(cfg_ddc1_en), .cfg_addr(cfg_addr), .sda_pull(sda_pull),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata), .ev_stop(ev_stop), .ev_restart(ev_restart),
      .ev_wstop(ev_wstop), .ddc1_ready(ddc1_ready)
   );

   always @(posedge clk) begin
      if (!rst_n) for (int i = 0; i < 128; i++) ram[i] <= 8'(i * 7 + 3);
      else if (mem_we) ram[mem_addr] <= mem_wdata;
   end

   // reference state
   int n_chk = 0, n_err = 0;
   int c_stop = 0, c_rst = 0, c_wstop = 0;
   int e_stop = 0, e_rst = 0, e_wstop = 0;
   bit m_busy = 0, m_wrote = 0, done = 0;
   logic [7:0] exp_mem [128];
   logic [7:0] txq [$];

   always @(negedge clk) if (rst_n) begin
      if (ev_stop)    c_stop++;
      if (ev_restart) c_rst++;
      if (ev_wstop)   c_wstop++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      if (m_busy && cfg_en) e_rst++;
      m_busy = 1;
      m_sda = 1; tick(1); scl = 1; tick(1); m_sda = 0; tick(1); scl = 0; tick(1);
   endtask

   task automatic bus_stop();
      m_sda = 0; tick(1); scl = 1; tick(1); m_sda = 1; tick(3);
      if (cfg_en) begin
         e_stop++;
         if (m_wrote) e_wstop++;
      end
      m_wrote = 0; m_busy = 0;
   endtask

   task automatic wbit(input logic b);
      m_sda = b; tick(1); scl = 1; tick(2); scl = 0; tick(1);
   endtask

   task automatic rbit(output logic b);
      m_sda = 1; tick(1); scl = 1; tick(1); b = sda_bus; tick(1); scl = 0; tick(1);
   endtask

   task automatic send(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic recv(output logic [7:0] v, input logic ack);
      for (int i = 7; i >= 0; i--) rbit(v[i]);
      wbit(~ack);
   endtask

   task automatic probe(input logic [6:0] a, input logic exp_ack, input string tag);
      logic ack;
      bus_start();
      send({a, 1'b0}, ack);
      if (exp_ack && cfg_en) m_wrote = 1;
      bus_stop();
      check(tag, ack, exp_ack);
   endtask

   // write transfer: offset byte then txq contents, all must be acknowledged
   task automatic wr_txn(input logic [7:0] off, input bit do_stop, input string tag);
      logic ack;
      int all_ok = 1, eo;
      bus_start();
      send({OWN, 1'b0}, ack); all_ok &= ack; m_wrote = 1;
      send(off, ack); all_ok &= ack;
      eo = off & 8'h7F;
      foreach (txq[i]) begin
         send(txq[i], ack); all_ok &= ack;
         if (cfg_wr_permit) exp_mem[eo] = txq[i];
         eo = (eo + 1) % 128;
      end
      if (do_stop) bus_stop();
      check(tag, all_ok, 1);
   endtask

   task automatic cmp_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < 128; i++) if (ram[i] !== exp_mem[i]) bad++;
      check(tag, bad, 0);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      logic [7:0] rd;
      logic ack;
      for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 7 + 3);
      tick(4); rst_n = 1; tick(2);

      // reset state
      check("R4 reset pull", sda_pull, 0);
      check("R5 reset we", mem_we, 0);
      check("R10 reset ready off", ddc1_ready, 0);

      // R1 full compare
      probe(OWN, 1, "R1 own addr acks");
      probe(7'h51, 0, "R1 low bit differs nacks");
      cfg_alen = 2'b11;
      probe(7'h51, 0, "R1 code 11 compares 7 bits");
      probe(OWN, 1, "R1 code 11 own addr");
      // R2 five-bit compare
      cfg_alen = 2'b10;
      probe(7'h53, 1, "R2 low two bits ignored");
      probe(7'h54, 0, "R2 bit 2 compared");
      // R3 six-bit compare
      cfg_alen = 2'b01;
      probe(7'h51, 1, "R3 bit 0 ignored");
      probe(7'h52, 0, "R3 bit 1 compared");
      cfg_alen = 2'b00;

      // R5 write with offset
      txq = '{8'hA1, 8'hB2, 8'hC3};
      wr_txn(8'h10, 1, "R5 write acks");
      cmp_mem("R5 three bytes stored");
      // R5 wrap, top bit of offset byte ignored
      txq = '{8'h11, 8'h22};
      wr_txn(8'hFF, 1, "R5 wrap acks");
      check("R5 wrap last entry", ram[127], 8'h11);
      check("R5 wrap entry zero", ram[0], 8'h22);
      // R6 blocked writes
      cfg_wr_permit = 0;
      txq = '{8'h5A, 8'h5B};
      wr_txn(8'h20, 1, "R6 blocked bytes acked");
      cmp_mem("R6 memory unchanged");
      cfg_wr_permit = 1;

      // R7 read stream after offset set, with repeated start
      txq.delete();
      wr_txn(8'h10, 0, "R7 offset set");
      bus_start();
      send({OWN, 1'b1}, ack);
      check("R7 read address acked", ack, 1);
      recv(rd, 1); check("R7 read byte 0", rd, 8'hA1);
      recv(rd, 1); check("R7 read byte 1", rd, 8'hB2);
      recv(rd, 0); check("R7 read byte 2", rd, 8'hC3);
      check("R7 released after nack", sda_pull, 0);
      bus_stop();
      check("R8 restart counted", c_rst, e_rst);
      check("R9 write then read gives write-stop", c_wstop, e_wstop);
      // R7 offset continues, R9 read-only transfer
      bus_start();
      send({OWN, 1'b1}, ack);
      recv(rd, 0);
      check("R7 offset continues", rd, exp_mem[8'h13]);
      bus_stop();
      check("R9 read-only no write-stop", c_wstop, e_wstop);

      // R4 disabled
      cfg_en = 0;
      probe(OWN, 0, "R4 disabled no ack");
      txq = '{8'h77};
      bus_start(); send({OWN, 1'b0}, ack); send(8'h30, ack); send(8'h77, ack); bus_stop();
      check("R4 disabled data no ack", ack, 0);
      cmp_mem("R4 disabled memory unchanged");
      cfg_en = 1; tick(2);

      // R10 ready
      cfg_ddc1_en = 1; tick(2);
      check("R10 ready when idle", ddc1_ready, 1);
      bus_start();
      check("R10 ready low while busy", ddc1_ready, 0);
      send({OWN, 1'b0}, ack); m_wrote = 1;
      bus_stop();
      check("R10 ready after stop", ddc1_ready, 1);
      cfg_en = 0; tick(2);
      check("R10 ready off when disabled", ddc1_ready, 0);
      cfg_en = 1; cfg_ddc1_en = 0; tick(2);
      check("R10 ready off when mode off", ddc1_ready, 0);

      tick(4);
      check("R8 stop pulses", c_stop, e_stop);
      check("R8 restart pulses", c_rst, e_rst);
      check("R9 write-stop pulses", c_wstop, e_wstop);
      done = 1;
      summary();
   end
endmodule